// File: doc/BRIEF.md
# Dual-Group Clock Divider

This block derives two related clock groups from one fast source clock. A single position counter, clocked by the selected source, steps through one Group B period of 2N source cycles. Group A is decoded from that count at the source divided by N, and Group B at the source divided by 2N. A two-bit select picks N from three divisors. The fourth select code is rejected: it silences every output and raises a flag.

A test input moves the divider from the oscillator clock to a reference clock input. The division ratios are the same on either source. Select and test changes are latched only when a Group B period ends, so a period that has started always runs to the end. Every Group B rising edge falls on a Group A rising edge. After a synchronous reset both groups start in phase on the first source edge. Six Group A lines and five Group B lines each carry their group's waveform.

Top module: `clkdiv_dual`

## Requirements
- R1: The select `fsel` chooses the Group A divisor N: 2'b10 gives N=4, 2'b00 gives N=5, 2'b01 gives N=6. The Group A period is N source cycles.
- R2: The Group B period is 2N source cycles. Group B is high for the first N cycles of that period.
- R3: Group A is high for floor(N/2) source cycles of each period. That is 2 of 4, 2 of 5 (a 40/60 duty) and 3 of 6.
- R4: With `fsel` = 2'b11 all outputs stay low and `mode_invalid` is 1. With any other code `mode_invalid` is 0.
- R5: With `test_en` = 1 the divider counts `ref_clk` cycles instead of `osc_clk` cycles, using the same ratios.
- R6: Every rising edge of Group B happens at the same instant as a rising edge of Group A.
- R7: All six `grp_a` bits are always equal to each other, and all five `grp_b` bits are always equal to each other.
- R8: A change of `fsel` or `test_en` takes effect only when the current Group B period ends. A Group B period that has begun keeps its old length and high time.
- R9: While `rst_n` is low at a source edge, all outputs are low. On the first source edge after `rst_n` goes high, both groups rise together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Fast oscillator clock, the normal source |
| ref_clk | input | 1 | Reference clock, the source when test_en is 1 |
| rst_n | input | 1 | Synchronous active-low reset, sampled on the selected source |
| test_en | input | 1 | 1 selects ref_clk as the source |
| fsel | input | 2 | Divisor select code |
| grp_a | output | 6 | Group A clock lines at source / N |
| grp_b | output | 5 | Group B clock lines at source / 2N |
| mode_invalid | output | 1 | High while the unused select code is in force |

## Verification
Two functions can act in the same cycle: a Group A wrap and the Group B period boundary where a new select is latched. Both then decide the next output values together. The bench changes `fsel` a few cycles into a Group B high phase. It then times that phase's fall and the next rise, which must still follow the old divisor. It then checks that the period after the boundary follows the new divisor, and that Group A rose at the same time as Group B at that edge.

// File: rtl/clkdiv_pkg.sv
// Shared definitions for the dual-group clock divider.
// Assumes: the select field is two bits wide; the code values below are
// fixed, because the surrounding board straps decode to them.
package clkdiv_pkg;

    // Select code values; SEL_NONE is the rejected code.
    typedef enum logic [1:0] {
        SEL_MID  = 2'b00,
        SEL_SLOW = 2'b01,
        SEL_FAST = 2'b10,
        SEL_NONE = 2'b11
    } fsel_code_e;

endpackage

// File: rtl/clkdiv_mode_latch.sv
// Holds the active divisor and source choice.
// Samples the select and test pins during reset and at each Group B period
// boundary, and holds them at all other times.
// Assumes: boundary comes from the counter in the same clock domain.
module clkdiv_mode_latch #(
    parameter int DIV_FAST = 4,
    parameter int DIV_MID  = 5,
    parameter int DIV_SLOW = 6,
    parameter int DIV_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       fsel,
    input  logic             test_en,
    input  logic             boundary,
    output logic [DIV_W-1:0] n_q,
    output logic             valid_q,
    output logic             sel_ref_q,
    output logic [DIV_W-1:0] n_nxt,
    output logic             valid_nxt
);
    import clkdiv_pkg::*;

    logic             take;
    logic [DIV_W-1:0] dec_n;
    logic             dec_valid;
    logic             sel_nxt;

    // Decode the select pins into a divisor and a validity bit.
    always_comb begin
        dec_valid = 1'b1;
        case (fsel_code_e'(fsel))
            SEL_FAST: dec_n = DIV_W'(DIV_FAST);
            SEL_MID:  dec_n = DIV_W'(DIV_MID);
            SEL_SLOW: dec_n = DIV_W'(DIV_SLOW);
            default: begin
                dec_n     = DIV_W'(DIV_FAST);
                dec_valid = 1'b0;
            end
        endcase
    end

    // Choose between the sampled pins and the held mode.
    always_comb begin
        take      = !rst_n || boundary;
        n_nxt     = take ? dec_n     : n_q;
        valid_nxt = take ? dec_valid : valid_q;
        sel_nxt   = take ? test_en   : sel_ref_q;
    end

    // Register the active mode.
    always_ff @(posedge clk) begin
        n_q       <= n_nxt;
        valid_q   <= valid_nxt;
        sel_ref_q <= sel_nxt;
    end

    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> ($stable(n_q) && $stable(sel_ref_q) && $stable(valid_q)));

endmodule

// File: rtl/clkdiv_counter.sv
// Position counter over one Group B period (2N source cycles), plus
// registered decode of both group waveforms from the next count.
// Assumes: n_nxt differs from n_q only at a boundary or in reset, so a
// divisor change always meets a count of zero.
module clkdiv_counter #(
    parameter int DIV_W = 3,
    parameter int CW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] n_q,
    input  logic [DIV_W-1:0] n_nxt,
    input  logic             valid_nxt,
    output logic             boundary,
    output logic             a_q,
    output logic             b_q
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nxt;
    logic [CW-1:0] last_pos;
    logic [CW-1:0] n_new;
    logic [CW-1:0] a_pos;
    logic          a_d;
    logic          b_d;

    // Find the last slot of the period and the next count.
    always_comb begin
        last_pos = (CW'(n_q) << 1) - CW'(1);
        boundary = (cnt >= last_pos);
        cnt_nxt  = boundary ? '0 : cnt + CW'(1);
    end

    // Decode the next output levels under the mode that will be in force.
    always_comb begin
        n_new = CW'(n_nxt);
        a_pos = (cnt_nxt < n_new) ? cnt_nxt : cnt_nxt - n_new;
        a_d   = valid_nxt && (a_pos < (n_new >> 1));
        b_d   = valid_nxt && (cnt_nxt < n_new);
    end

    // Step the count; reset parks it past the end so that release wraps to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '1;
            a_q <= 1'b0;
            b_q <= 1'b0;
        end else begin
            cnt <= cnt_nxt;
            a_q <= a_d;
            b_q <= b_d;
        end
    end

    // R6
    edge_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(b_q) |-> $rose(a_q));

    // R2
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (cnt < (CW'(n_q) << 1)));

endmodule

// File: rtl/clkdiv_dual.sv
// Top of the dual-group divider: source clock select, mode latch, counter
// and fan-out to the group lines.
// Assumes: the source switch is a plain multiplexer; switching clean
// clocks is left to the surrounding clock network.
module clkdiv_dual #(
    parameter int NUM_A    = 6,
    parameter int NUM_B    = 5,
    parameter int DIV_FAST = 4,
    parameter int DIV_MID  = 5,
    parameter int DIV_SLOW = 6
) (
    input  logic             osc_clk,
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             test_en,
    input  logic [1:0]       fsel,
    output logic [NUM_A-1:0] grp_a,
    output logic [NUM_B-1:0] grp_b,
    output logic             mode_invalid
);
    localparam int DIV_MAX = (DIV_FAST > DIV_MID)
                           ? ((DIV_FAST > DIV_SLOW) ? DIV_FAST : DIV_SLOW)
                           : ((DIV_MID > DIV_SLOW) ? DIV_MID : DIV_SLOW);
    localparam int DIV_W   = $clog2(DIV_MAX + 1);
    localparam int CW      = $clog2(2 * DIV_MAX);

    logic             src_clk;
    logic             sel_ref_q;
    logic             boundary;
    logic [DIV_W-1:0] n_q;
    logic [DIV_W-1:0] n_nxt;
    logic             valid_q;
    logic             valid_nxt;
    logic             a_q;
    logic             b_q;

    // Pick the counting source.
    assign src_clk = sel_ref_q ? ref_clk : osc_clk;

    clkdiv_mode_latch #(
        .DIV_FAST (DIV_FAST),
        .DIV_MID  (DIV_MID),
        .DIV_SLOW (DIV_SLOW),
        .DIV_W    (DIV_W)
    ) u_mode (
        .clk       (src_clk),
        .rst_n     (rst_n),
        .fsel      (fsel),
        .test_en   (test_en),
        .boundary  (boundary),
        .n_q       (n_q),
        .valid_q   (valid_q),
        .sel_ref_q (sel_ref_q),
        .n_nxt     (n_nxt),
        .valid_nxt (valid_nxt)
    );

    clkdiv_counter #(
        .DIV_W (DIV_W),
        .CW    (CW)
    ) u_cnt (
        .clk       (src_clk),
        .rst_n     (rst_n),
        .n_q       (n_q),
        .n_nxt     (n_nxt),
        .valid_nxt (valid_nxt),
        .boundary  (boundary),
        .a_q       (a_q),
        .b_q       (b_q)
    );

    // Fan the Group A waveform out to its lines.
    generate
        for (genvar i = 0; i < NUM_A; i++) begin : g_fan_a
            assign grp_a[i] = a_q;
        end
        for (genvar j = 0; j < NUM_B; j++) begin : g_fan_b
            assign grp_b[j] = b_q;
        end
    endgenerate

    // Report the rejected code from the registered mode.
    assign mode_invalid = !valid_q;

    // R4
    invalid_quiet_chk: assert property (@(posedge src_clk) disable iff (!rst_n)
        mode_invalid |-> (grp_a == '0 && grp_b == '0));

    // R9
    reset_low_chk: assert property (@(posedge src_clk)
        !rst_n |=> (grp_a == '0 && grp_b == '0));

endmodule

// File: tb/clkdiv_dual_tb.sv
`timescale 1ns/1ps
module clkdiv_dual_tb;
    localparam int TO = 8;   // oscillator period, 125 MHz
    localparam int TR = 20;  // reference period

    logic       osc_clk = 1'b0;
    logic       ref_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic       test_en = 1'b0;
    logic [1:0] fsel    = 2'b10;
    logic [5:0] grp_a;
    logic [4:0] grp_b;
    logic       mode_invalid;

    int  vec = 0;
    int  bad = 0;
    time ta_rise = 0;
    bit  done = 0;

    clkdiv_dual u_dut (
        .osc_clk      (osc_clk),
        .ref_clk      (ref_clk),
        .rst_n        (rst_n),
        .test_en      (test_en),
        .fsel         (fsel),
        .grp_a        (grp_a),
        .grp_b        (grp_b),
        .mode_invalid (mode_invalid)
    );

    initial forever #(TO/2) osc_clk = ~osc_clk;
    initial forever #(TR/2) ref_clk = ~ref_clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    endtask

    // R6: at each Group B rise, Group A must have risen at the same instant
    always @(posedge grp_b[0]) begin
        time tb_rise;
        tb_rise = $time;
        #1;
        if (rst_n)
            chk(ta_rise == tb_rise && grp_a[0], "R6 align", longint'(ta_rise), longint'(tb_rise));
    end
    always @(posedge grp_a[0]) ta_rise = $time;

    // Time one period and the high time of group A (which=0) or B (which=1).
    task automatic meas(input bit which, output longint per, output longint hi);
        time t0, t1, t2;
        if (!which) begin
            @(posedge grp_a[0]); t0 = $time;
            @(negedge grp_a[0]); t1 = $time;
            @(posedge grp_a[0]); t2 = $time;
        end else begin
            @(posedge grp_b[0]); t0 = $time;
            @(negedge grp_b[0]); t1 = $time;
            @(posedge grp_b[0]); t2 = $time;
        end
        per = longint'(t2 - t0);
        hi  = longint'(t1 - t0);
    endtask

    // R7: sample the lines of each group off the edges.
    task automatic chk_groups();
        for (int k = 0; k < 20; k++) begin
            #3;
            chk(grp_a == '0 || grp_a == '1, "R7 group A lines", longint'(grp_a), 0);
            chk(grp_b == '0 || grp_b == '1, "R7 group B lines", longint'(grp_b), 0);
        end
    endtask

    // R9: outputs low in reset, both groups rise on the first edge after release.
    task automatic t_reset();
        time tr;
        rst_n = 0; fsel = 2'b10; test_en = 0;
        repeat (5) @(negedge osc_clk);
        chk(grp_a == '0 && grp_b == '0, "R9 low in reset", longint'({grp_a, grp_b}), 0);
        chk(mode_invalid == 1'b0, "R4 flag low on valid code", longint'(mode_invalid), 0);
        rst_n = 1;
        tr = $time;
        @(posedge grp_a[0]);
        chk($time - tr == TO/2, "R9 first rise", longint'($time - tr), TO/2);
        #1;
        chk(grp_b[0] == 1'b1, "R9 B rises with A", longint'(grp_b[0]), 1);
    endtask

    // R1 R2 R3 R5: one mode, settled, timed on both groups.
    task automatic t_mode(input logic [1:0] code, input bit tst, input int n, input int tp, input string req);
        longint per, hi;
        fsel = code; test_en = tst;
        #600;
        meas(0, per, hi);
        chk(per == n*tp, {req, " R1 A period"}, per, n*tp);
        chk(hi == (n/2)*tp, {req, " R3 A high"}, hi, (n/2)*tp);
        meas(1, per, hi);
        chk(per == 2*n*tp, {req, " R2 B period"}, per, 2*n*tp);
        chk(hi == n*tp, {req, " R2 B high"}, hi, n*tp);
        chk(mode_invalid == 1'b0, {req, " R4 flag"}, longint'(mode_invalid), 0);
        chk_groups();
    endtask

    // R4: the rejected code silences the outputs and raises the flag.
    task automatic t_invalid();
        longint per, hi;
        fsel = 2'b11;
        #600;
        for (int k = 0; k < 20; k++) begin
            #3;
            chk(grp_a == '0 && grp_b == '0, "R4 outputs low", longint'({grp_a, grp_b}), 0);
            chk(mode_invalid == 1'b1, "R4 flag high", longint'(mode_invalid), 1);
        end
        fsel = 2'b10;
        #600;
        chk(mode_invalid == 1'b0, "R4 flag clears", longint'(mode_invalid), 0);
        meas(0, per, hi);
        chk(per == 4*TO, "R4 recovery period", per, 4*TO);
    endtask

    // R8: a mid-period select change waits for the Group B boundary.
    task automatic t_deferred();
        time t0, t1, t2, t3;
        fsel = 2'b01; test_en = 0;
        #600;
        @(posedge grp_b[0]); t0 = $time;
        #(2*TO + 1);
        fsel = 2'b10;
        @(negedge grp_b[0]); t1 = $time;
        chk(t1 - t0 == 6*TO, "R8 old high time kept", longint'(t1 - t0), 6*TO);
        @(posedge grp_b[0]); t2 = $time;
        chk(t2 - t0 == 12*TO, "R8 old period kept", longint'(t2 - t0), 12*TO);
        #1;
        chk(ta_rise == t2, "R8 R6 align at boundary", longint'(ta_rise), longint'(t2));
        @(posedge grp_b[0]); t3 = $time;
        chk(t3 - t2 == 8*TO, "R8 new period", longint'(t3 - t2), 8*TO);
    endtask

    initial begin
        t_reset();
        t_mode(2'b10, 0, 4, TO, "div4");
        t_mode(2'b00, 0, 5, TO, "div5");
        t_mode(2'b01, 0, 6, TO, "div6");
        t_mode(2'b10, 1, 4, TR, "R5 div4");
        t_mode(2'b00, 1, 5, TR, "R5 div5");
        t_mode(2'b01, 1, 6, TR, "R5 div6");
        t_mode(2'b00, 0, 5, TO, "back to osc");
        t_invalid();
        t_deferred();
        report();
    end

    initial begin
        #200000;
        bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        report();
    end
endmodule